// File: doc/BRIEF.md
# Interrupt and Status Flag Unit

This block collects event pulses from the surrounding logic of a serial-attached controller and keeps them as sticky flags in two 32-bit registers. One register records bus-side framing and access errors. The other records device events such as supply faults, wake-ups and timeouts. Software reads both through a small register port and acknowledges a flag by writing a one to its bit. Each register also shows a few bits that are not sticky: live inputs and summaries that are derived from other state, which a write cannot change.

A mask register can hide individual bus errors from the error summary. An enable register decides which device events may drive the active-low interrupt pin. The pin is also driven by the error summary and by the interrupt line of the attached CAN core. Reads are combinational from the register state. Flag updates take effect at the clock edge that samples the pulse or the write.

Top module: `intflag_unit`

## Requirements
- R1: A one on `stat_evt[i]` for a single cycle sets status flag bit p(i) at the next clock edge, where p(i)=16+i for i=0..5 and p(i)=18+i for i=6..11. The flag then reads back as 1 at address 0x00C and stays set.
- R2: A write to 0x00C clears exactly those flags (bits 29..24, 21..16) whose data bit is 1. Writing 0 leaves a flag unchanged. Status bits 5, 4 and 3 read `stat_live[2]`, `stat_live[1]` and `stat_live[0]`, and a write does not alter them.
- R3: When an event pulse and a write-one-to-clear of the same flag fall in one cycle, the flag stays set. This holds for both flag registers.
- R4: The mask register at 0x010 stores only bits 29..24 and 21..16 and reads 0 elsewhere; a mask bit of 1 hides that error. Status bit 1 is the OR of the unmasked error flags. Status bit 2 is the OR of flags 29..27, whatever the mask. Status bit 0 is 1 while the interrupt pin is asserted.
- R5: A one on `dev_evt[j]` sets interrupt flag q(j) at 0x820, with q = 8,10,13,14,15,16,18,19,20,21,22,23 for j = 0..11. A write of ones clears the flags at those positions.
- R6: Interrupt bits 31, 6 and 5 read `dev_live[2]`, `dev_live[1]` and `dev_live[0]`. Bit 1 reads `core_irq`. Bit 3 equals status bit 1. Bit 7 is 1 when any flag of R5 is set or bit 3 is set. No write changes these bits.
- R7: The enable register at 0x830 stores only bits 22, 21, 19, 16, 15, 14, 10 and 8 and reads 0 elsewhere.
- R8: `irq_n` is 0 exactly when an interrupt flag is set together with its enable bit, the error summary of R4 is 1, or `core_irq` is 1.
- R9: Any other address reads 0, and a write to it changes no register.
- R10: After reset all flags, the mask and the enables are 0, and `irq_n` is 1 while `core_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| stat_evt | input | 12 | Bus error event pulses |
| stat_live | input | 3 | Live status levels for bits 5..3 |
| dev_evt | input | 12 | Device event pulses |
| dev_live | input | 3 | Live device levels for bits 31, 6, 5 |
| core_irq | input | 1 | Interrupt line of the CAN core |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
Every one of the 24 event inputs is pulsed on its own, with nothing else set. This separates a wrong bit position, a missing clearable bit and a summary that follows the wrong flag. Each flag is then cleared with an all-zero write and with a single-bit write, which shows whether a write clears only the bits it names. The device sweep runs twice, with the enables off and then on, so that enabled and non-enabled positions are told apart at the pin. Further patterns cover collisions between an event and its clear, masking of each error, all-ones writes against live and summary bits, and unmapped addresses.

// File: rtl/isf_pkg.sv
package isf_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;
    localparam int N_EV   = 12;
    localparam int N_LIVE = 3;

    localparam logic [ADDR_W-1:0] ADDR_STAT  = 12'h00C;
    localparam logic [ADDR_W-1:0] ADDR_EMASK = 12'h010;
    localparam logic [ADDR_W-1:0] ADDR_IRQ   = 12'h820;
    localparam logic [ADDR_W-1:0] ADDR_IEN   = 12'h830;

    // Sticky, clearable positions and writable configuration positions
    localparam logic [REG_W-1:0] STAT_ERR_M = 32'h3F3F_0000;
    localparam logic [REG_W-1:0] IRQ_CLR_M  = 32'h00FD_E500;
    localparam logic [REG_W-1:0] IEN_M      = 32'h0069_C500;
    localparam logic [REG_W-1:0] INT_ERR_M  = 32'h3800_0000;

    // Derived / live bit positions of the two flag registers
    localparam int ST_LIVE_LO = 3;
    localparam int ST_INTERR  = 2;
    localparam int ST_SPISUM  = 1;
    localparam int ST_PIN     = 0;
    localparam int IR_BUSNOM  = 31;
    localparam int IR_GLOBAL  = 7;
    localparam int IR_WAKE    = 6;
    localparam int IR_CANERR  = 5;
    localparam int IR_SPISUM  = 3;
    localparam int IR_CORE    = 1;

    typedef struct packed {
        logic stat;
        logic emask;
        logic irq;
        logic ien;
    } reg_sel_t;

    function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.stat  = (a == ADDR_STAT);
        s.emask = (a == ADDR_EMASK);
        s.irq   = (a == ADDR_IRQ);
        s.ien   = (a == ADDR_IEN);
        return s;
    endfunction

    // Place successive event bits onto the set positions of a mask, LSB first
    function automatic logic [REG_W-1:0] scatter(input logic [REG_W-1:0] m,
                                                 input logic [N_EV-1:0]  ev);
        logic [REG_W-1:0] r;
        logic [3:0]       k;
        r = '0;
        k = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (m[i]) begin
                r[i] = ev[k];
                k    = k + 4'd1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/isf_flag_bank.sv
module isf_flag_bank
    import isf_pkg::*;
#(
    parameter int              W     = REG_W,
    parameter logic [W-1:0]    CLR_M = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_en ? (clr_vec & CLR_M) : '0;
    end

    // Set has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_eff) | (set_vec & CLR_M);
    end
endmodule

// File: rtl/isf_cfg_reg.sv
module isf_cfg_reg
    import isf_pkg::*;
#(
    parameter int           W     = REG_W,
    parameter logic [W-1:0] WR_M  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wd & WR_M;
    end
endmodule

// File: rtl/intflag_unit.sv
module intflag_unit
    import isf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_EV-1:0]   stat_evt,
    input  logic [N_LIVE-1:0] stat_live,
    input  logic [N_EV-1:0]   dev_evt,
    input  logic [N_LIVE-1:0] dev_live,
    input  logic              core_irq,
    output logic              irq_n
);
    reg_sel_t         sel;
    logic [REG_W-1:0] stat_set, irq_set;
    logic [REG_W-1:0] stat_flags, irq_flags, err_mask, ien;
    logic [REG_W-1:0] stat_view, irq_view;
    logic             spi_sum, int_err, pin_act;

    assign sel      = decode(reg_addr);
    assign stat_set = scatter(STAT_ERR_M, stat_evt);
    assign irq_set  = scatter(IRQ_CLR_M, dev_evt);

    isf_flag_bank #(.W(REG_W), .CLR_M(STAT_ERR_M)) u_stat (
        .clk(clk), .rst(rst), .set_vec(stat_set),
        .clr_en(reg_wr & sel.stat), .clr_vec(reg_wdata), .flags(stat_flags)
    );

    isf_flag_bank #(.W(REG_W), .CLR_M(IRQ_CLR_M)) u_irq (
        .clk(clk), .rst(rst), .set_vec(irq_set),
        .clr_en(reg_wr & sel.irq), .clr_vec(reg_wdata), .flags(irq_flags)
    );

    isf_cfg_reg #(.W(REG_W), .WR_M(STAT_ERR_M)) u_emask (
        .clk(clk), .rst(rst), .we(reg_wr & sel.emask), .wd(reg_wdata), .q(err_mask)
    );

    isf_cfg_reg #(.W(REG_W), .WR_M(IEN_M)) u_ien (
        .clk(clk), .rst(rst), .we(reg_wr & sel.ien), .wd(reg_wdata), .q(ien)
    );

    always_comb begin
        spi_sum = |(stat_flags & ~err_mask);
        int_err = |(stat_flags & INT_ERR_M);
        pin_act = (|(irq_flags & ien)) | spi_sum | core_irq;
    end

    assign irq_n = ~pin_act;

    always_comb begin
        stat_view = stat_flags;
        stat_view[ST_LIVE_LO +: N_LIVE] = stat_live;
        stat_view[ST_INTERR]            = int_err;
        stat_view[ST_SPISUM]            = spi_sum;
        stat_view[ST_PIN]               = pin_act;

        irq_view = irq_flags;
        irq_view[IR_BUSNOM] = dev_live[2];
        irq_view[IR_WAKE]   = dev_live[1];
        irq_view[IR_CANERR] = dev_live[0];
        irq_view[IR_GLOBAL] = (|irq_flags) | spi_sum;
        irq_view[IR_SPISUM] = spi_sum;
        irq_view[IR_CORE]   = core_irq;
    end

    always_comb begin
        if (sel.stat)       reg_rdata = stat_view;
        else if (sel.emask) reg_rdata = err_mask;
        else if (sel.irq)   reg_rdata = irq_view;
        else if (sel.ien)   reg_rdata = ien;
        else                reg_rdata = '0;
    end
endmodule

// File: rtl/isf_checker.sv
module isf_checker
    import isf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [N_EV-1:0]   stat_evt,
    input logic [N_EV-1:0]   dev_evt,
    input logic              core_irq,
    input logic              irq_n,
    input logic [REG_W-1:0]  stat_flags,
    input logic [REG_W-1:0]  irq_flags
);
    // R1 and R3: a status event always leaves its flag set
    a_r1_stat_event_sets: assert property (@(posedge clk) disable iff (rst)
        (stat_evt != '0) |=>
        ((stat_flags & $past(scatter(STAT_ERR_M, stat_evt))) == $past(scatter(STAT_ERR_M, stat_evt))));

    // R5 and R3: a device event always leaves its flag set
    a_r5_irq_event_sets: assert property (@(posedge clk) disable iff (rst)
        (dev_evt != '0) |=>
        ((irq_flags & $past(scatter(IRQ_CLR_M, dev_evt))) == $past(scatter(IRQ_CLR_M, dev_evt))));

    // R2: flags hold without a write or an event
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && stat_evt == '0) |=> $stable(stat_flags));

    // R2: a write of ones clears the named flags when no event collides
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_STAT && stat_evt == '0) |=>
        ((stat_flags & $past(reg_wdata & STAT_ERR_M)) == '0));

    // R8: the core line alone asserts the pin
    a_r8_core_pin: assert property (@(posedge clk) disable iff (rst)
        core_irq |-> !irq_n);

    // R9: unmapped addresses read zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != ADDR_STAT && reg_addr != ADDR_EMASK &&
         reg_addr != ADDR_IRQ && reg_addr != ADDR_IEN) |-> (reg_rdata == '0));
endmodule

bind intflag_unit isf_checker u_chk (.*);

// File: tb/tb_intflag_unit.sv
module tb_intflag_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SM = 32'h3F3F_0000;
    localparam logic [31:0] IM = 32'h00FD_E500;
    localparam logic [31:0] EM = 32'h0069_C500;
    localparam logic [11:0] A_ST = 12'h00C, A_MK = 12'h010, A_IR = 12'h820, A_IE = 12'h830;

    logic        clk = 1'b0, rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] stat_evt = '0, dev_evt = '0;
    logic [2:0]  stat_live = '0, dev_live = '0;
    logic        core_irq = 1'b0;
    logic        irq_n;

    intflag_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_stat = '0, m_mask = '0, m_irq = '0, m_ien = '0;

    function automatic int spos(int i);
        return (i < 6) ? 16 + i : 18 + i;
    endfunction

    function automatic int ipos(int i);
        int t[12] = '{8, 10, 13, 14, 15, 16, 18, 19, 20, 21, 22, 23};
        return t[i];
    endfunction

    function automatic logic [31:0] evmap(logic [11:0] e, bit dev);
        logic [31:0] r = '0;
        for (int i = 0; i < 12; i++)
            if (e[i]) r[dev ? ipos(i) : spos(i)] = 1'b1;
        return r;
    endfunction

    function automatic logic m_sum();
        return |(m_stat & ~m_mask & SM);
    endfunction

    function automatic logic m_pin();
        return (|(m_irq & m_ien)) | m_sum() | core_irq;
    endfunction

    function automatic logic [31:0] view(logic [11:0] a);
        logic [31:0] v = '0;
        case (a)
            A_ST: begin
                v = m_stat | ({29'b0, stat_live} << 3);
                v[2] = |m_stat[29:27];
                v[1] = m_sum();
                v[0] = m_pin();
            end
            A_MK: v = m_mask;
            A_IR: begin
                v = m_irq;
                v[31] = dev_live[2]; v[6] = dev_live[1]; v[5] = dev_live[0];
                v[7] = (|m_irq) | m_sum();
                v[3] = m_sum();
                v[1] = core_irq;
            end
            A_IE: v = m_ien;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // combinational read at the current address, plus the pin
    task automatic rd(logic [11:0] a, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, view(a));
        chk({tag, " R8 pin"}, {31'b0, irq_n}, {31'b0, ~m_pin()});
    endtask

    // one clock cycle with optional write and event pulses; starts and ends at a falling edge
    task automatic cyc(bit w, logic [11:0] a, logic [31:0] d, logic [11:0] se, logic [11:0] de);
        reg_wr = w; reg_addr = a; reg_wdata = d; stat_evt = se; dev_evt = de;
        if (w) begin
            case (a)
                A_ST: m_stat = m_stat & ~(d & SM);
                A_MK: m_mask = d & SM;
                A_IR: m_irq  = m_irq & ~(d & IM);
                A_IE: m_ien  = d & EM;
                default: ;
            endcase
        end
        m_stat = m_stat | evmap(se, 1'b0);
        m_irq  = m_irq  | evmap(de, 1'b1);
        @(negedge clk);
        reg_wr = 1'b0; stat_evt = '0; dev_evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(A_ST, "R10 status"); rd(A_MK, "R10 mask"); rd(A_IR, "R10 irq"); rd(A_IE, "R10 ien");

        // R1 R2 R4 R6 R8: each status error on its own
        for (int i = 0; i < 12; i++) begin
            cyc(0, A_ST, 0, 12'(1) << i, 0);
            rd(A_ST, "R1 R4 status set");
            rd(A_IR, "R6 irq summary");
            cyc(1, A_ST, 32'h0, 0, 0);
            rd(A_ST, "R2 zero write keeps");
            cyc(1, A_ST, 32'h1 << spos(i), 0, 0);
            rd(A_ST, "R2 clear one");
        end

        // R4: mask each error in turn
        for (int i = 0; i < 12; i++) begin
            cyc(1, A_MK, 32'h1 << spos(i), 12'(1) << i, 0);
            rd(A_ST, "R4 masked error");
            rd(A_IR, "R4 masked summary");
            cyc(1, A_MK, 32'h0, 0, 0);
            rd(A_ST, "R4 unmasked error");
            cyc(1, A_ST, 32'hFFFF_FFFF, 0, 0);
            rd(A_ST, "R2 clear all");
        end

        // R5 R8: device events with enables off, then on
        for (int pass = 0; pass < 2; pass++) begin
            cyc(1, A_IE, pass ? 32'hFFFF_FFFF : 32'h0, 0, 0);
            for (int j = 0; j < 12; j++) begin
                cyc(0, A_IR, 0, 0, 12'(1) << j);
                rd(A_IR, "R5 irq set");
                cyc(1, A_IR, 32'h1 << ipos(j), 0, 0);
                rd(A_IR, "R5 irq clear");
            end
        end

        // R7 R4: writable field widths
        cyc(1, A_IE, 32'hFFFF_FFFF, 0, 0); rd(A_IE, "R7 ien readback");
        cyc(1, A_MK, 32'hFFFF_FFFF, 0, 0); rd(A_MK, "R4 mask readback");
        cyc(1, A_MK, 32'h0, 0, 0);

        // R3: collision of event and clear
        cyc(1, A_ST, 32'hFFFF_FFFF, 12'h801, 0); rd(A_ST, "R3 status collision");
        cyc(1, A_IR, 32'hFFFF_FFFF, 0, 12'h401); rd(A_IR, "R3 irq collision");
        cyc(1, A_ST, 32'hFFFF_FFFF, 0, 0);
        cyc(1, A_IR, 32'hFFFF_FFFF, 0, 0);
        rd(A_ST, "R3 status cleared after"); rd(A_IR, "R3 irq cleared after");

        // R6 R2 R8: live inputs and core line against all-ones writes
        stat_live = 3'b101; dev_live = 3'b110; core_irq = 1'b1;
        cyc(1, A_IR, 32'hFFFF_FFFF, 0, 0); rd(A_IR, "R6 live and core");
        cyc(1, A_ST, 32'hFFFF_FFFF, 0, 0); rd(A_ST, "R2 live status");
        stat_live = 3'b010; dev_live = 3'b001; core_irq = 1'b0;
        rd(A_IR, "R6 live change"); rd(A_ST, "R2 live change");

        // R9: unmapped addresses
        cyc(0, A_ST, 0, 12'hFFF, 12'hFFF);
        rd(12'h004, "R9 read 004"); rd(12'h824, "R9 read 824");
        cyc(1, 12'h824, 32'hFFFF_FFFF, 0, 0);
        cyc(1, 12'h014, 32'hFFFF_FFFF, 0, 0);
        rd(A_ST, "R9 status after stray write"); rd(A_IR, "R9 irq after stray write");
        rd(A_IE, "R9 ien after stray write"); rd(A_MK, "R9 mask after stray write");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule